// File: doc/BRIEF.md
# Coincident-Current Core Cycle Sequencer

This controller runs one complete access to a coincident-current magnetic core plane as a series of timed phases. Every access starts with a read phase. Current flows through one X line and one Y line in the direction that clears the selected cores to zero. A core that held a one gives a sense pulse on its bit line, and a core that held zero gives none. The sequencer latches these pulses during a strobe window at the end of the read phase.

A write phase follows. Current flows the other way on the same two lines and would set every selected core to one. For each bit that must stay zero, the sequencer raises an inhibit output so that core is not set. On a read request the word written back is the captured sense word, so the destructive read is undone. On a write request the word written is the request data. A recovery phase with no drive then returns the block to idle.

The request port is valid/ready. `req_ready` is high only while idle, and a request is taken in the clock where both `req_valid` and `req_ready` are high. While the block is busy, `req_ready` is low and a requester must hold its request until the block is idle again. A request offered while busy is not queued. The read result comes out as a one-clock `rd_valid` pulse with no back-pressure, and `rd_data` keeps its value until the next read result.

Top module: `core_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A `req_valid` presented while busy is ignored and changes no core of the plane.
- R2: After a request is accepted, `busy` rises on the next clock. Read drive (`x_rd_en`, `y_rd_en`) then holds for READ_CYC+STROBE_CYC cycles. Write drive (`x_wr_en`, `y_wr_en`) holds for WRITE_CYC cycles after that. RECOV_CYC cycles follow with no drive, and then `busy` falls.
- R3: Read drive and write drive are never active in the same clock, and the X and Y enables of one direction are always active together.
- R4: While either drive is active, exactly one X line and exactly one Y line are high. The X line index is address bits [X_BITS-1:0] and the Y line index is the remaining upper address bits. Both lines stay fixed for the whole access, and no line is high when there is no drive.
- R5: `sense` is sampled only in the last STROBE_CYC cycles of read drive. Pulses at any other time have no effect on the captured word.
- R6: For a read request, `rd_valid` pulses for one clock in the first write-drive cycle, with `rd_data` equal to the word the addressed cores held. `rd_data` holds that value afterwards.
- R7: During write drive, `inhibit` is the bitwise inverse of the data being stored, and it is all zeros at every other time. The data being stored is the captured word for a read request (restore) and `req_wdata` for a write request.
- R8: A write request never raises `rd_valid`.
- R9: After reset the block is idle: `req_ready` is 1, and `busy`, all drive enables, all lines, `inhibit` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High while idle; request accepted when both are high |
| req_write | input | 1 | 1 = store req_wdata, 0 = read and restore |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write request |
| rd_valid | output | 1 | One-clock pulse with the read result |
| rd_data | output | DATA_W | Captured word, held until the next read |
| sense | input | DATA_W | Per-bit sense pulses from the plane |
| inhibit | output | DATA_W | Per-bit inhibit during write drive |
| x_rd_en | output | 1 | X read-direction drive |
| y_rd_en | output | 1 | Y read-direction drive |
| x_wr_en | output | 1 | X write-direction drive |
| y_wr_en | output | 1 | Y write-direction drive |
| x_line | output | 2**X_BITS | One-hot X line select |
| y_line | output | 2**(ADDR_W-X_BITS) | One-hot Y line select |
| busy | output | 1 | High from acceptance to the end of recovery |

## Verification
Some properties are checked on every clock: that the two drive directions never overlap, that the line selects are one-hot and unchanging within an access, that inhibit appears only under write drive, that write drive always follows read drive, and that the result pulse sits on the first write cycle. Other behaviour can only be shown by the bench's scenarios, using a behavioural core plane that clears on coincident read drive and sets uninhibited bits on coincident write drive. These scenarios cover correct restoration of the word after a read, stored write data, phase lengths, immunity to sense noise outside the strobe, and requests offered while busy leaving other words untouched.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_STROBE = 3'd2,
    PH_WRITE  = 3'd3,
    PH_RECOV  = 3'd4
  } phase_t;
endpackage

// File: rtl/core_phase_ctrl.sv
module core_phase_ctrl
  import core_seq_pkg::*;
#(
  parameter int READ_CYC   = 2,
  parameter int STROBE_CYC = 1,
  parameter int WRITE_CYC  = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   launch,
  output phase_t phase,
  output logic   strobe_last
);
  localparam int MAX_A = (READ_CYC > STROBE_CYC) ? READ_CYC : STROBE_CYC;
  localparam int MAX_B = (WRITE_CYC > RECOV_CYC) ? WRITE_CYC : RECOV_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  logic [CNT_W-1:0] cnt;
  logic             last;

  function automatic int phase_len(input phase_t p);
    case (p)
      PH_READ:   return READ_CYC;
      PH_STROBE: return STROBE_CYC;
      PH_WRITE:  return WRITE_CYC;
      PH_RECOV:  return RECOV_CYC;
      default:   return 1;
    endcase
  endfunction

  function automatic phase_t phase_next(input phase_t p);
    case (p)
      PH_READ:   return PH_STROBE;
      PH_STROBE: return PH_WRITE;
      PH_WRITE:  return PH_RECOV;
      default:   return PH_IDLE;
    endcase
  endfunction

  assign last        = (int'(cnt) == phase_len(phase) - 1);
  assign strobe_last = (phase == PH_STROBE) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (launch) phase <= PH_READ;
    end else if (last) begin
      phase <= phase_next(phase);
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/core_line_decode.sv
module core_line_decode #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]      sel,
  input  logic                  en,
  output logic [(1<<SEL_W)-1:0] lines
);
  localparam int N = 1 << SEL_W;
  for (genvar g = 0; g < N; g++) begin : g_line
    assign lines[g] = en && (sel == SEL_W'(g));
  end
endmodule

// File: rtl/core_data_path.sv
module core_data_path
  import core_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase,
  input  logic              strobe_last,
  input  logic [DATA_W-1:0] sense,
  output logic [DATA_W-1:0] inhibit,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              is_wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] store_word;

  assign store_word = is_wr_q ? wdata_q : cap_q;
  assign inhibit    = (phase == PH_WRITE) ? ~store_word : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_wr_q  <= 1'b0;
      wdata_q  <= '0;
      cap_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= strobe_last && !is_wr_q;
      if (launch) begin
        is_wr_q <= req_write;
        wdata_q <= req_wdata;
        cap_q   <= '0;
      end else if (phase == PH_STROBE) begin
        cap_q <= cap_q | sense;
      end
      if (strobe_last && !is_wr_q) rd_data <= cap_q | sense;
    end
  end
endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
  import core_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int X_BITS     = 3,
  parameter int READ_CYC   = 2,
  parameter int STROBE_CYC = 1,
  parameter int WRITE_CYC  = 3,
  parameter int RECOV_CYC  = 2,
  localparam int Y_BITS    = ADDR_W - X_BITS,
  localparam int X_LINES   = 1 << X_BITS,
  localparam int Y_LINES   = 1 << Y_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [DATA_W-1:0]  sense,
  output logic [DATA_W-1:0]  inhibit,
  output logic               x_rd_en,
  output logic               y_rd_en,
  output logic               x_wr_en,
  output logic               y_wr_en,
  output logic [X_LINES-1:0] x_line,
  output logic [Y_LINES-1:0] y_line,
  output logic               busy
);
  phase_t            phase;
  logic              strobe_last;
  logic              launch;
  logic              rd_drive;
  logic              wr_drive;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = !req_ready;
  assign launch    = req_valid && req_ready;
  assign rd_drive  = (phase == PH_READ) || (phase == PH_STROBE);
  assign wr_drive  = (phase == PH_WRITE);
  assign x_rd_en   = rd_drive;
  assign y_rd_en   = rd_drive;
  assign x_wr_en   = wr_drive;
  assign y_wr_en   = wr_drive;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (launch) addr_q <= req_addr;
  end

  core_phase_ctrl #(
    .READ_CYC(READ_CYC), .STROBE_CYC(STROBE_CYC),
    .WRITE_CYC(WRITE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .phase(phase), .strobe_last(strobe_last)
  );

  core_line_decode #(.SEL_W(X_BITS)) u_xdec (
    .sel(addr_q[X_BITS-1:0]), .en(rd_drive || wr_drive), .lines(x_line)
  );

  core_line_decode #(.SEL_W(Y_BITS)) u_ydec (
    .sel(addr_q[ADDR_W-1:X_BITS]), .en(rd_drive || wr_drive), .lines(y_line)
  );

  core_data_path #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .req_write(req_write), .req_wdata(req_wdata),
    .phase(phase), .strobe_last(strobe_last), .sense(sense),
    .inhibit(inhibit), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/core_cycle_seq_chk.sv
module core_cycle_seq_chk #(
  parameter int DATA_W  = 8,
  parameter int X_LINES = 8,
  parameter int Y_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rd_valid,
  input logic [DATA_W-1:0]  inhibit,
  input logic               x_rd_en,
  input logic               y_rd_en,
  input logic               x_wr_en,
  input logic               y_wr_en,
  input logic [X_LINES-1:0] x_line,
  input logic [Y_LINES-1:0] y_line,
  input logic               busy
);
  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((x_rd_en || y_rd_en) && (x_wr_en || y_wr_en))); // R3

  AST_ONE_LINE_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd_en || x_wr_en) |-> ($countones(x_line) == 1 && $countones(y_line) == 1)); // R4

  AST_NO_LINE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_rd_en || x_wr_en || y_rd_en || y_wr_en) |-> (x_line == '0 && y_line == '0)); // R4

  AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_rd_en || x_wr_en) && $past(x_rd_en || x_wr_en)) |-> ($stable(x_line) && $stable(y_line))); // R4

  AST_INHIBIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != '0) |-> (x_wr_en && y_wr_en)); // R7

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && x_rd_en && y_rd_en)); // R2

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_wr_en) |-> $past(x_rd_en)); // R2

  AST_RESULT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (x_wr_en && !$past(x_wr_en))); // R6

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!x_rd_en && !x_wr_en && inhibit == '0)); // R1
endmodule

bind core_cycle_seq core_cycle_seq_chk #(
  .DATA_W(DATA_W), .X_LINES(X_LINES), .Y_LINES(Y_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .inhibit(inhibit),
  .x_rd_en(x_rd_en), .y_rd_en(y_rd_en), .x_wr_en(x_wr_en), .y_wr_en(y_wr_en),
  .x_line(x_line), .y_line(y_line), .busy(busy)
);

// File: tb/sim_core_cycle_seq.sv
`timescale 1ns/1ps
module sim_core_cycle_seq;
  localparam int DW = 8, AW = 6, XB = 3;
  localparam int RC = 2, SC = 1, WC = 3, CC = 2;
  localparam int RS = RC + SC, TOT = RC + SC + WC + CC;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, busy, x_rd_en, y_rd_en, x_wr_en, y_wr_en;
  logic [DW-1:0] rd_data, inhibit, sense;
  logic [7:0] x_line, y_line;

  always #2.5 clk = ~clk;

  core_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sense(sense), .inhibit(inhibit),
    .x_rd_en(x_rd_en), .y_rd_en(y_rd_en), .x_wr_en(x_wr_en), .y_wr_en(y_wr_en),
    .x_line(x_line), .y_line(y_line), .busy(busy)
  );

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] plane   [NW];
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] noise_mask = '0, noise_now = '0;

  // Behavioural core plane
  function automatic int hot_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  int sel_now;
  always_comb begin
    sel_now = hot_idx(y_line) * 8 + hot_idx(x_line);
    sense = ((x_rd_en && y_rd_en) ? plane[sel_now] : '0) | noise_now;
  end

  logic rd_seen = 0;
  int   rd_sel = 0;
  always @(posedge clk) begin
    if (x_rd_en && y_rd_en) begin
      rd_seen = 1; rd_sel = sel_now;
    end else begin
      if (rd_seen) begin plane[rd_sel] = '0; rd_seen = 0; end
      if (x_wr_en && y_wr_en) plane[sel_now] = plane[sel_now] | ~inhibit;
    end
  end

  // Reference model state
  bit m_act = 0, m_rd = 0;
  int m_t = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_old = '0, m_data = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit e_rd, e_wr;
    logic [7:0] ex, ey;
    logic [DW-1:0] e_inh;
    @(negedge clk);
    if (m_act) begin
      m_t++;
      if (m_t == TOT) m_act = 0;
    end else if (req_valid) begin
      m_act = 1; m_t = 0; m_rd = !req_write; m_addr = req_addr;
      m_old = ref_mem[req_addr];
      m_data = req_write ? req_wdata : m_old;
      ref_mem[req_addr] = m_data;
    end
    e_rd  = m_act && m_t < RS;
    e_wr  = m_act && m_t >= RS && m_t < RS + WC;
    ex    = (e_rd || e_wr) ? 8'(1 << m_addr[XB-1:0]) : 8'h0;
    ey    = (e_rd || e_wr) ? 8'(1 << m_addr[AW-1:XB]) : 8'h0;
    e_inh = e_wr ? ~m_data : '0;
    chk(req_ready == !m_act, "R1 ready", 32'(req_ready), 32'(!m_act));
    chk(busy == m_act, "R2 busy", 32'(busy), 32'(m_act));
    chk(x_rd_en == e_rd && x_wr_en == e_wr, "R2 x drive", {x_rd_en, x_wr_en}, {e_rd, e_wr});
    chk(y_rd_en == x_rd_en && y_wr_en == x_wr_en, "R3 xy pair", {y_rd_en, y_wr_en}, {x_rd_en, x_wr_en});
    chk(x_line == ex && y_line == ey, "R4 lines", {y_line, x_line}, {ey, ex});
    chk(inhibit == e_inh, "R7 inhibit", 32'(inhibit), 32'(e_inh));
    chk(rd_valid == (m_act && m_rd && m_t == RS), m_rd ? "R6 rd_valid" : "R8 rd_valid",
        32'(rd_valid), 32'(m_act && m_rd && m_t == RS));
    if (m_act && m_rd && m_t == RS)
      chk(rd_data == m_old, "R6/R5 rd_data", 32'(rd_data), 32'(m_old));
    noise_now = (m_act && (m_t < RC || m_t >= RS)) ? noise_mask : '0;
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit spur, input logic [DW-1:0] nz);
    logic [AW-1:0] ja;
    ja = a ^ 6'h15;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; noise_mask = nz;
    tick();
    req_valid = 0;
    while (m_act) begin
      if (spur && (m_t % 2 == 0)) begin
        req_valid = 1; req_write = 1; req_addr = ja; req_wdata = 8'h00;
      end else req_valid = 0;
      tick();
    end
    req_valid = 0;
    chk(plane[a] == ref_mem[a], "R7 stored word", 32'(plane[a]), 32'(ref_mem[a]));
    if (spur)
      chk(plane[ja] == ref_mem[ja], "R1 ignored req", 32'(plane[ja]), 32'(ref_mem[ja]));
    tick();
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      plane[i]   = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !x_rd_en && !y_rd_en && !x_wr_en && !y_wr_en
        && x_line == 0 && y_line == 0 && inhibit == 0 && !rd_valid,
        "R9 reset", {busy, inhibit}, {1'b0, 8'h00});
    // read and restore a preloaded word, twice
    do_op(0, 6'h00, 8'h00, 0, 8'h00);
    do_op(0, 6'h00, 8'h00, 0, 8'h00);
    // writes of distinct patterns at corners
    do_op(1, 6'h3F, 8'hFF, 0, 8'h00);
    do_op(0, 6'h3F, 8'h00, 0, 8'h00);
    do_op(1, 6'h2A, 8'h00, 0, 8'h00);
    do_op(0, 6'h2A, 8'h00, 0, 8'h00);
    do_op(1, 6'h07, 8'hA5, 0, 8'h00);
    // sense noise outside the strobe window (R5)
    do_op(0, 6'h07, 8'h00, 0, 8'h5A);
    do_op(0, 6'h2A, 8'h00, 0, 8'hFF);
    // requests offered while busy (R1)
    do_op(1, 6'h11, 8'h3C, 1, 8'h00);
    do_op(0, 6'h11, 8'h00, 1, 8'hC3);
    do_op(0, 6'h38, 8'h00, 1, 8'h00);
    // back-to-back sweep
    for (int k = 0; k < 16; k++) begin
      do_op(1, 6'(k * 5), 8'(k * 29 + 1), 0, 8'h00);
      do_op(0, 6'(k * 5), 8'h00, 0, 8'(k));
    end
    // R8: rd_valid must stay low on writes (checked every cycle above)
    do_op(1, 6'h20, 8'h81, 0, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule